// File: doc/BRIEF.md
# CPU Low-Power Mode Controller

This block holds the power state of a processor core and turns it into clock-enable and halt controls for the peripherals around the core. There are four states: running, sleep, deep sleep and standby. When the core executes its sleep instruction, it pulses a request. The controller then picks the low-power state from bit 7 of two standby-control register values. The standby selection bit is tested first. The deep-sleep selection bit is tested only when the standby bit is clear.

Each low-power state halts a different set of peripherals:

- Standby stops the timer unit and the serial unit and halts DMA. In the request cycle, a synchronisation pulse lets both units catch up to that cycle before they stop.
- Deep sleep halts only DMA.
- Plain sleep leaves every peripheral clocked.

A pending interrupt request returns the controller to running from any low-power state. While the core sleeps, a pending timed event that is not an interrupt gets a service strobe and does not wake the core.

Top module: `cpu_power_mode_ctl`

## Requirements
- R1: After reset the state is RUNNING. The four state flags are runFlag=1, sleepFlag=0, deepFlag=0 and stbyFlag=0. timerClkEn and serialClkEn are 1 and dmaHalt is 0.
- R2: A sleep request accepted in RUNNING with stbyCtl[7]=1 makes stbyFlag the only flag set from the next clock edge. This holds whatever the value of deepCtl.
- R3: A sleep request accepted with stbyCtl[7]=0 enters DEEP_SLEEP when deepCtl[7]=1 and SLEEP when deepCtl[7]=0. Bits 6..0 of both control inputs have no effect.
- R4: In STANDBY, timerClkEn=0, serialClkEn=0 and dmaHalt=1. These outputs change on the same clock edge as the state flags.
- R5: In DEEP_SLEEP, dmaHalt=1 while timerClkEn=1 and serialClkEn=1. In SLEEP, both enables are 1 and dmaHalt=0.
- R6: periphSync is 1, combinationally, only in the cycle in which a sleep request toward STANDBY is accepted. It is 0 for requests toward SLEEP or DEEP_SLEEP.
- R7: irqPending=1 in any non-running state returns the controller to RUNNING at the next edge. The RUNNING output values then apply again.
- R8: In a non-running state, timedEvent=1 with irqPending=0 drives eventService=1 in that cycle and leaves the state unchanged. In RUNNING, eventService stays 0.
- R9: A sleep request in any state other than RUNNING is ignored.
- R10: A sleep request in RUNNING in the same cycle as irqPending=1 resolves to RUNNING, and periphSync stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | One-cycle pulse from the sleep instruction |
| stbyCtl | input | 8 | First standby-control register value; bit 7 selects standby |
| deepCtl | input | 8 | Second standby-control register value; bit 7 selects deep sleep |
| irqPending | input | 1 | An interrupt request is pending |
| timedEvent | input | 1 | A timed, non-interrupt event is pending |
| runFlag | output | 1 | State is RUNNING |
| sleepFlag | output | 1 | State is SLEEP |
| deepFlag | output | 1 | State is DEEP_SLEEP |
| stbyFlag | output | 1 | State is STANDBY |
| timerClkEn | output | 1 | Clock enable for the timer unit |
| serialClkEn | output | 1 | Clock enable for the serial unit |
| dmaHalt | output | 1 | Halt request to the DMA controller |
| periphSync | output | 1 | Catch-up pulse for timer and serial before standby |
| eventService | output | 1 | Service strobe for a timed event while the core sleeps |

## Verification
A wake-up interrupt and a sleep request can meet in one cycle. The bench raises irqPending in the same cycle as a sleep request that selects standby, while the core is running. The result is judged in two places:

- In that cycle, periphSync must stay low.
- After the following edge, the output vector must still be the RUNNING pattern.

A second overlap is a sleep request arriving while the core already sleeps. The bench expects the existing state and enables to be unchanged.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int NUM_STATES = 4;
  localparam int STATE_W = $clog2(NUM_STATES);

  typedef enum logic [STATE_W-1:0] {
    PWR_RUN   = 2'd0,
    PWR_SLEEP = 2'd1,
    PWR_DEEP  = 2'd2,
    PWR_STBY  = 2'd3
  } pwrState_t;

  typedef struct packed {
    pwrState_t nextState;
    logic      syncPulse;
    logic      evtService;
  } lpmStrobe_t;
endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int CTL_W   = 8,
  parameter int SEL_BIT = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepReq,
  input  logic [CTL_W-1:0] stbyCtl,
  input  logic [CTL_W-1:0] deepCtl,
  input  logic             irqPending,
  input  logic             timedEvent,
  output lpmStrobe_t       strobe
);
  pwrState_t curState;
  pwrState_t nextState;
  logic      syncPulse;
  logic      evtService;
  logic      acceptSleep;

  assign acceptSleep = (curState == PWR_RUN) && sleepReq && !irqPending;

  always_comb begin
    nextState  = curState;
    syncPulse  = 1'b0;
    evtService = 1'b0;
    if (curState == PWR_RUN) begin
      if (acceptSleep) begin
        if (stbyCtl[SEL_BIT]) begin
          nextState = PWR_STBY;
          syncPulse = 1'b1;
        end else if (deepCtl[SEL_BIT]) begin
          nextState = PWR_DEEP;
        end else begin
          nextState = PWR_SLEEP;
        end
      end
    end else begin
      if (irqPending) begin
        nextState = PWR_RUN;
      end else if (timedEvent) begin
        evtService = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= PWR_RUN;
    else       curState <= nextState;
  end

  assign strobe = '{nextState: nextState, syncPulse: syncPulse, evtService: evtService};

  AST_STBY_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (curState == PWR_RUN && sleepReq && !irqPending && stbyCtl[SEL_BIT]) |=> (curState == PWR_STBY)); // R2
  AST_WAKE_ON_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (curState != PWR_RUN && irqPending) |=> (curState == PWR_RUN)); // R7
  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (curState != PWR_RUN && !irqPending) |=> $stable(curState)); // R9
  AST_COLLIDE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (curState == PWR_RUN && irqPending) |=> (curState == PWR_RUN)); // R10
endmodule

// File: rtl/lpm_dp.sv
module lpm_dp
  import lpm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  lpmStrobe_t            strobe,
  output logic [NUM_STATES-1:0] stateFlags,
  output logic                  timerClkEn,
  output logic                  serialClkEn,
  output logic                  dmaHalt,
  output logic                  periphSync,
  output logic                  eventService
);
  localparam logic [NUM_STATES-1:0] RESET_FLAGS = NUM_STATES'(1);

  for (genvar i = 0; i < NUM_STATES; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stateFlags[i] <= RESET_FLAGS[i];
      else       stateFlags[i] <= (strobe.nextState == pwrState_t'(i));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerClkEn  <= 1'b1;
      serialClkEn <= 1'b1;
      dmaHalt     <= 1'b0;
    end else begin
      timerClkEn  <= (strobe.nextState != PWR_STBY);
      serialClkEn <= (strobe.nextState != PWR_STBY);
      dmaHalt     <= (strobe.nextState == PWR_DEEP) || (strobe.nextState == PWR_STBY);
    end
  end

  assign periphSync   = strobe.syncPulse;
  assign eventService = strobe.evtService;

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stateFlags) == 1); // R1
  AST_STBY_GATES: assert property (@(posedge clk) disable iff (!rstN)
    stateFlags[PWR_STBY] |-> (!timerClkEn && !serialClkEn && dmaHalt)); // R4
  AST_DEEP_GATES: assert property (@(posedge clk) disable iff (!rstN)
    stateFlags[PWR_DEEP] |-> (timerClkEn && serialClkEn && dmaHalt)); // R5
  AST_RUN_EVT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    stateFlags[PWR_RUN] |-> !eventService); // R8
endmodule

// File: rtl/cpu_power_mode_ctl.sv
module cpu_power_mode_ctl
  import lpm_pkg::*;
#(
  parameter int CTL_W   = 8,
  parameter int SEL_BIT = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepReq,
  input  logic [CTL_W-1:0] stbyCtl,
  input  logic [CTL_W-1:0] deepCtl,
  input  logic             irqPending,
  input  logic             timedEvent,
  output logic             runFlag,
  output logic             sleepFlag,
  output logic             deepFlag,
  output logic             stbyFlag,
  output logic             timerClkEn,
  output logic             serialClkEn,
  output logic             dmaHalt,
  output logic             periphSync,
  output logic             eventService
);
  lpmStrobe_t            strobe;
  logic [NUM_STATES-1:0] stateFlags;

  lpm_ctrl #(.CTL_W(CTL_W), .SEL_BIT(SEL_BIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .stbyCtl(stbyCtl),
    .deepCtl(deepCtl), .irqPending(irqPending), .timedEvent(timedEvent),
    .strobe(strobe)
  );

  lpm_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stateFlags(stateFlags),
    .timerClkEn(timerClkEn), .serialClkEn(serialClkEn), .dmaHalt(dmaHalt),
    .periphSync(periphSync), .eventService(eventService)
  );

  assign runFlag   = stateFlags[PWR_RUN];
  assign sleepFlag = stateFlags[PWR_SLEEP];
  assign deepFlag  = stateFlags[PWR_DEEP];
  assign stbyFlag  = stateFlags[PWR_STBY];
endmodule

// File: tb/cpu_power_mode_ctl_tb_top.sv
module cpu_power_mode_ctl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0;
  logic [7:0] stbyCtl = 8'h00;
  logic [7:0] deepCtl = 8'h00;
  logic irqPending = 1'b0;
  logic timedEvent = 1'b0;
  logic runFlag, sleepFlag, deepFlag, stbyFlag;
  logic timerClkEn, serialClkEn, dmaHalt, periphSync, eventService;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam int S_RUN = 0, S_SLEEP = 1, S_DEEP = 2, S_STBY = 3;

  always #10 clk = ~clk;

  cpu_power_mode_ctl dut_i (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .stbyCtl(stbyCtl),
    .deepCtl(deepCtl), .irqPending(irqPending), .timedEvent(timedEvent),
    .runFlag(runFlag), .sleepFlag(sleepFlag), .deepFlag(deepFlag),
    .stbyFlag(stbyFlag), .timerClkEn(timerClkEn), .serialClkEn(serialClkEn),
    .dmaHalt(dmaHalt), .periphSync(periphSync), .eventService(eventService)
  );

  // {run,sleep,deep,stby,timerEn,serialEn,dmaHalt}
  function automatic logic [6:0] expVec(int st);
    case (st)
      S_RUN:   return 7'b1000_110;
      S_SLEEP: return 7'b0100_110;
      S_DEEP:  return 7'b0010_111;
      default: return 7'b0001_001;
    endcase
  endfunction

  function automatic logic [6:0] actVec();
    return {runFlag, sleepFlag, deepFlag, stbyFlag, timerClkEn, serialClkEn, dmaHalt};
  endfunction

  task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", actVec(), expVec(S_RUN));
  endtask

  task automatic doSleep(logic [7:0] sc, logic [7:0] dc, int expSt, logic expSync, string req);
    @(negedge clk);
    stbyCtl = sc; deepCtl = dc; sleepReq = 1'b1;
    #1 chk({req, " R6 periphSync"}, {6'b0, periphSync}, {6'b0, expSync});
    @(negedge clk);
    sleepReq = 1'b0; stbyCtl = 8'h00; deepCtl = 8'h00;
    chk(req, actVec(), expVec(expSt));
  endtask

  task automatic doWake(string req);
    @(negedge clk);
    irqPending = 1'b1;
    @(negedge clk);
    irqPending = 1'b0;
    chk(req, actVec(), expVec(S_RUN));
  endtask

  task automatic doEvent(int curSt, logic expSvc, string req);
    @(negedge clk);
    timedEvent = 1'b1;
    #1 chk({req, " eventService"}, {6'b0, eventService}, {6'b0, expSvc});
    @(negedge clk);
    timedEvent = 1'b0;
    chk({req, " state kept"}, actVec(), expVec(curSt));
  endtask

  task automatic doIgnore(int curSt);
    @(negedge clk);
    stbyCtl = 8'h80; sleepReq = 1'b1;
    #1 chk("R9 no sync when not running", {6'b0, periphSync}, 7'b0);
    @(negedge clk);
    sleepReq = 1'b0; stbyCtl = 8'h00;
    chk("R9 request ignored", actVec(), expVec(curSt));
  endtask

  task automatic doCollide();
    @(negedge clk);
    stbyCtl = 8'h80; sleepReq = 1'b1; irqPending = 1'b1;
    #1 chk("R10 no sync on collision", {6'b0, periphSync}, 7'b0);
    @(negedge clk);
    sleepReq = 1'b0; irqPending = 1'b0; stbyCtl = 8'h00;
    chk("R10 stays running", actVec(), expVec(S_RUN));
  endtask

  initial begin
    doReset();
    // R2 standby wins over deep bit
    doSleep(8'h80, 8'h80, S_STBY, 1'b1, "R2/R4 standby");
    doEvent(S_STBY, 1'b1, "R8 standby event");
    doIgnore(S_STBY);
    doWake("R7 wake from standby");
    // R3 low bits ignored
    doSleep(8'h7F, 8'h80, S_DEEP, 1'b0, "R3/R5 deep sleep");
    doIgnore(S_DEEP);
    doWake("R7 wake from deep");
    doSleep(8'h7F, 8'h7F, S_SLEEP, 1'b0, "R3/R5 plain sleep");
    doEvent(S_SLEEP, 1'b1, "R8 sleep event");
    doWake("R7 wake from sleep");
    doEvent(S_RUN, 1'b0, "R8 running event");
    doCollide();
    doSleep(8'h00, 8'h00, S_SLEEP, 1'b0, "R3 sleep zero ctl");
    doWake("R7 wake again");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule